// File: doc/BRIEF.md
# Transport-Triggered Move Processor Core

This block is a small processor with one instruction: a move. Each instruction copies one value from a source register to a destination register. The registers belong to functional units that share a transport bus. Computation is a side effect of the move. Writing a unit's trigger register starts that unit's operation, and writing a plain operand register only stores the value. The core fetches one 32-bit move per cycle from an instruction port that answers in the same cycle. It drives the selected source onto the bus and writes the bus into the selected destination at the clock edge.

The units are selected by a fixed number in the upper nibble of each address:

- 0: fetch unit, for jumps and reading the program counter.
- 1: memory unit, for external data accesses that take several cycles.
- 2: general register file.
- 3: arithmetic unit.
- 4: network port, a transmit register and a receive register.

A source unit nibble of 0xF selects the immediate field of the instruction. Software builds a program from moves, for example: load an operand, write a trigger, then move the result out.

Top module: `move_core`

## Requirements
- R1: An instruction holds the destination address in bits [31:24], the source address in bits [23:16] and an immediate in bits [15:0]. In each address the upper nibble is the unit number and the lower nibble is the register. When the source unit nibble is 0xF, the bus carries the immediate sign-extended to 32 bits. The program counter advances by one for every executed move that is not a jump.
- R2: The unit numbers are fixed: 0 fetch, 1 memory, 2 register file, 3 arithmetic, 4 network.
- R3: Arithmetic unit. Destination 0x30 stores operand A. Destinations 0x31 to 0x36 are triggers that compute, from operand A and the bus value B:
  - 0x31: A+B
  - 0x32: A-B
  - 0x33: A AND B
  - 0x34: A OR B
  - 0x35: A XOR B
  - 0x36: equality compare, giving 1 or 0
  
  The result is read at source 0x37 by the very next move.
- R4: Result registers are read-only. A move whose destination is 0x37 (arithmetic result), 0x13 (load data) or 0x41 (network receive) changes nothing that can later be read.
- R5: Register file entry i is written at destination 0x2i and read at source 0x2i. Writes are kept until overwritten.
- R6: Memory unit registers:
  - 0x10: address register.
  - 0x11: store trigger. The bus value is written to the address held in 0x10.
  - 0x12: load trigger. The bus value is the address.
  - 0x13 (source): load data.
  
  memEn is held high for exactly 3 cycles on a load and 2 cycles on a store. memWe is high only for stores, and memAddr holds the access address. No move executes and instAddr stays constant while memEn is high.
- R7: Fetch unit. Destination 0x00 loads the program counter from the bus. Destination 0x01 loads it only when the last compare result was nonzero, and otherwise behaves like a normal move. Source 0x00 reads the address of the instruction after the current one.
- R8: Network port. A move to 0x40 presents the value on netTxData with netTxValid high for exactly one cycle, in the cycle after the move. Source 0x41 reads netRxData.
- R9: While reset is held, instAddr is 0 and memEn and netTxValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| instAddr | output | PC_W | Address of the instruction being executed |
| instData | input | 32 | Move instruction at instAddr, valid in the same cycle |
| memEn | output | 1 | External data access in progress |
| memWe | output | 1 | Access is a store |
| memAddr | output | DATA_W | Data access address |
| memWdata | output | DATA_W | Store data |
| memRdata | input | DATA_W | Load data, sampled in the last cycle of a load |
| netTxData | output | DATA_W | Network transmit word |
| netTxValid | output | 1 | One-cycle strobe marking a new transmit word |
| netRxData | input | DATA_W | Network receive word |

## Verification
The test program is a sequence of moves. Each one routes a result out through the network transmit register, so a scoreboard can compare every emitted word in order.

- The arithmetic triggers use operands with the sign bit set and with mixed bit patterns. A wrong opcode decode, a missing sign extension, or swapped operands then gives a different word.
- Writes to the result registers are each followed by a read-back. A write that was wrongly accepted shows up as a changed value.
- A store is followed by a load of the same address. This separates the 2-cycle and 3-cycle access windows, and it also shows whether the store address came from the address register.
- The conditional jump is tried with the compare flag both clear and set. The markers placed on the skipped path expose a jump taken or missed in the wrong case.

// File: rtl/move_core_pkg.sv
package move_core_pkg;

  localparam logic [3:0] UNIT_FETCH = 4'h0;
  localparam logic [3:0] UNIT_MEM   = 4'h1;
  localparam logic [3:0] UNIT_RF    = 4'h2;
  localparam logic [3:0] UNIT_ALU   = 4'h3;
  localparam logic [3:0] UNIT_NET   = 4'h4;
  localparam logic [3:0] UNIT_IMM   = 4'hF;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_CMP = 3'd5
  } aluOp_e;

  typedef struct packed {
    logic        rfWe;
    logic [3:0]  rfIdx;
    logic        aluAWe;
    logic        aluTrig;
    aluOp_e      aluOp;
    logic        memAddrWe;
    logic        memStore;
    logic        memLoad;
    logic        netTx;
    logic [3:0]  srcUnit;
    logic [3:0]  srcReg;
    logic [15:0] imm;
  } ctrlStrobes_t;

endpackage

// File: rtl/move_alu.sv
module move_alu
  import move_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aWe,
  input  logic              trig,
  input  aluOp_e            op,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] result,
  output logic              cmpFlag
);

  logic [DATA_W-1:0] nextResult;

  always_comb begin
    unique case (op)
      ALU_ADD: nextResult = opA + busData;
      ALU_SUB: nextResult = opA - busData;
      ALU_AND: nextResult = opA & busData;
      ALU_OR:  nextResult = opA | busData;
      ALU_XOR: nextResult = opA ^ busData;
      ALU_CMP: nextResult = {{(DATA_W-1){1'b0}}, (opA == busData)};
      default: nextResult = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA     <= '0;
      result  <= '0;
      cmpFlag <= 1'b0;
    end else begin
      if (aWe) opA <= busData;
      if (trig) begin
        result <= nextResult;
        if (op == ALU_CMP) cmpFlag <= (opA == busData);
      end
    end
  end

endmodule

// File: rtl/move_memport.sv
module move_memport #(
  parameter int DATA_W       = 32,
  parameter int LOAD_CYCLES  = 3,
  parameter int STORE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWe,
  input  logic              store,
  input  logic              load,
  input  logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              memEn,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] addrReg,
  output logic [DATA_W-1:0] loadData
);

  localparam int MAX_CYC = (LOAD_CYCLES > STORE_CYCLES) ? LOAD_CYCLES : STORE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0]  remain;
  logic              isStore;
  logic [DATA_W-1:0] accAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      remain   <= '0;
      isStore  <= 1'b0;
      accAddr  <= '0;
      memWdata <= '0;
      addrReg  <= '0;
      loadData <= '0;
    end else if (busy) begin
      if (remain == '0) begin
        busy <= 1'b0;
        if (!isStore) loadData <= memRdata;
      end else begin
        remain <= remain - 1'b1;
      end
    end else begin
      if (addrWe) addrReg <= busData;
      if (store) begin
        busy     <= 1'b1;
        isStore  <= 1'b1;
        memWdata <= busData;
        accAddr  <= addrReg;
        remain   <= CNT_W'(STORE_CYCLES - 1);
      end else if (load) begin
        busy    <= 1'b1;
        isStore <= 1'b0;
        accAddr <= busData;
        remain  <= CNT_W'(LOAD_CYCLES - 1);
      end
    end
  end

  assign memEn   = busy;
  assign memWe   = busy & isStore;
  assign memAddr = accAddr;

endmodule

// File: rtl/move_ctrl.sv
module move_ctrl
  import move_core_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instData,
  input  logic [DATA_W-1:0] busData,
  input  logic              cmpFlag,
  input  logic              stall,
  output logic [PC_W-1:0]   instAddr,
  output logic [PC_W-1:0]   pcPlusOne,
  output ctrlStrobes_t      ctrl
);

  logic [3:0] dstUnit;
  logic [3:0] dstReg;
  logic       exec;
  logic       takeJump;
  logic [PC_W-1:0] pc;

  assign dstUnit   = instData[31:28];
  assign dstReg    = instData[27:24];
  assign exec      = !stall;
  assign pcPlusOne = pc + 1'b1;
  assign instAddr  = pc;

  always_comb begin
    ctrl           = '0;
    ctrl.srcUnit   = instData[23:20];
    ctrl.srcReg    = instData[19:16];
    ctrl.imm       = instData[15:0];
    ctrl.rfIdx     = dstReg;
    ctrl.rfWe      = exec && (dstUnit == UNIT_RF);
    ctrl.aluAWe    = exec && (dstUnit == UNIT_ALU) && (dstReg == 4'd0);
    ctrl.aluTrig   = exec && (dstUnit == UNIT_ALU) && (dstReg >= 4'd1) && (dstReg <= 4'd6);
    ctrl.aluOp     = aluOp_e'(3'(dstReg - 4'd1));
    ctrl.memAddrWe = exec && (dstUnit == UNIT_MEM) && (dstReg == 4'd0);
    ctrl.memStore  = exec && (dstUnit == UNIT_MEM) && (dstReg == 4'd1);
    ctrl.memLoad   = exec && (dstUnit == UNIT_MEM) && (dstReg == 4'd2);
    ctrl.netTx     = exec && (dstUnit == UNIT_NET) && (dstReg == 4'd0);
  end

  assign takeJump = exec && (dstUnit == UNIT_FETCH) &&
                    ((dstReg == 4'd0) || ((dstReg == 4'd1) && cmpFlag));

  always_ff @(posedge clk) begin
    if (!rstN) pc <= '0;
    else if (exec) pc <= takeJump ? busData[PC_W-1:0] : pcPlusOne;
  end

endmodule

// File: rtl/move_datapath.sv
module move_datapath
  import move_core_pkg::*;
#(
  parameter int PC_W         = 8,
  parameter int DATA_W       = 32,
  parameter int RF_DEPTH     = 8,
  parameter int LOAD_CYCLES  = 3,
  parameter int STORE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic [PC_W-1:0]   pcPlusOne,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] netRxData,
  output logic [DATA_W-1:0] busData,
  output logic              cmpFlag,
  output logic              stall,
  output logic [DATA_W-1:0] aluResult,
  output logic              memEn,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] netTxData,
  output logic              netTxValid
);

  logic [DATA_W-1:0] rfData [RF_DEPTH];
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] addrReg;
  logic [DATA_W-1:0] loadData;

  genvar g;
  generate
    for (g = 0; g < RF_DEPTH; g++) begin : gRf
      always_ff @(posedge clk) begin
        if (!rstN) rfData[g] <= '0;
        else if (ctrl.rfWe && (ctrl.rfIdx == 4'(g))) rfData[g] <= busData;
      end
    end
  endgenerate

  move_alu #(.DATA_W(DATA_W)) uAlu (
    .clk(clk), .rstN(rstN), .aWe(ctrl.aluAWe), .trig(ctrl.aluTrig),
    .op(ctrl.aluOp), .busData(busData), .opA(opA), .result(aluResult),
    .cmpFlag(cmpFlag)
  );

  move_memport #(.DATA_W(DATA_W), .LOAD_CYCLES(LOAD_CYCLES),
                 .STORE_CYCLES(STORE_CYCLES)) uMem (
    .clk(clk), .rstN(rstN), .addrWe(ctrl.memAddrWe), .store(ctrl.memStore),
    .load(ctrl.memLoad), .busData(busData), .memRdata(memRdata),
    .busy(stall), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .addrReg(addrReg), .loadData(loadData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      netTxData  <= '0;
      netTxValid <= 1'b0;
    end else begin
      netTxValid <= ctrl.netTx;
      if (ctrl.netTx) netTxData <= busData;
    end
  end

  always_comb begin
    busData = '0;
    unique case (ctrl.srcUnit)
      UNIT_FETCH: if (ctrl.srcReg == 4'd0) busData = DATA_W'(pcPlusOne);
      UNIT_MEM: begin
        if (ctrl.srcReg == 4'd0) busData = addrReg;
        else if (ctrl.srcReg == 4'd3) busData = loadData;
      end
      UNIT_RF: if (int'(ctrl.srcReg) < RF_DEPTH) busData = rfData[ctrl.srcReg[$clog2(RF_DEPTH)-1:0]];
      UNIT_ALU: begin
        if (ctrl.srcReg == 4'd0) busData = opA;
        else if (ctrl.srcReg == 4'd7) busData = aluResult;
      end
      UNIT_NET: begin
        if (ctrl.srcReg == 4'd0) busData = netTxData;
        else if (ctrl.srcReg == 4'd1) busData = netRxData;
      end
      UNIT_IMM: busData = {{(DATA_W-16){ctrl.imm[15]}}, ctrl.imm};
      default: busData = '0;
    endcase
  end

endmodule

// File: rtl/move_core.sv
module move_core
  import move_core_pkg::*;
#(
  parameter int PC_W         = 8,
  parameter int DATA_W       = 32,
  parameter int RF_DEPTH     = 8,
  parameter int LOAD_CYCLES  = 3,
  parameter int STORE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [PC_W-1:0]   instAddr,
  input  logic [31:0]       instData,
  output logic              memEn,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] netTxData,
  output logic              netTxValid,
  input  logic [DATA_W-1:0] netRxData
);

  ctrlStrobes_t      ctrl;
  logic [DATA_W-1:0] busData;
  logic [PC_W-1:0]   pcPlusOne;
  logic              cmpFlag;
  logic              stall;
  logic [DATA_W-1:0] aluResult;

  move_ctrl #(.PC_W(PC_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .instData(instData), .busData(busData),
    .cmpFlag(cmpFlag), .stall(stall), .instAddr(instAddr),
    .pcPlusOne(pcPlusOne), .ctrl(ctrl)
  );

  move_datapath #(.PC_W(PC_W), .DATA_W(DATA_W), .RF_DEPTH(RF_DEPTH),
                  .LOAD_CYCLES(LOAD_CYCLES), .STORE_CYCLES(STORE_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pcPlusOne(pcPlusOne),
    .memRdata(memRdata), .netRxData(netRxData), .busData(busData),
    .cmpFlag(cmpFlag), .stall(stall), .aluResult(aluResult),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .netTxData(netTxData), .netTxValid(netTxValid)
  );

endmodule

// File: rtl/move_core_checker.sv
module move_core_checker #(
  parameter int PC_W         = 8,
  parameter int DATA_W       = 32,
  parameter int LOAD_CYCLES  = 3,
  parameter int STORE_CYCLES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   instAddr,
  input logic [31:0]       instData,
  input logic              memEn,
  input logic              memWe,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] aluResult
);

  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (memEn) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  // R6: access window length
  assert_mem_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memEn) |-> (runLen == ($past(memWe) ? 16'(STORE_CYCLES) : 16'(LOAD_CYCLES))));

  // R6: core frozen, access signals steady during access
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && $past(memEn)) |-> ($stable(instAddr) && $stable(memWe) && $stable(memAddr)));

  // R6: an access only starts from a memory trigger move
  assert_mem_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memEn) |-> ($past(instData[31:24]) == 8'h11 || $past(instData[31:24]) == 8'h12));

  // R1: sequential advance on non-jump moves
  assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!memEn && instData[31:28] != 4'h0) |=> (instAddr == PC_W'($past(instAddr) + 1'b1)));

  // R7: unconditional jump with an immediate target
  assert_jump_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memEn && instData[31:24] == 8'h00 && instData[23:20] == 4'hF)
      |=> (instAddr == $past(instData[PC_W-1:0])));

  // R4: arithmetic result register ignores moves into it
  assert_result_ro_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memEn && instData[31:24] == 8'h37) |=> $stable(aluResult));

endmodule

bind move_core move_core_checker #(
  .PC_W(PC_W), .DATA_W(DATA_W), .LOAD_CYCLES(LOAD_CYCLES), .STORE_CYCLES(STORE_CYCLES)
) uChecker (
  .clk(clk), .rstN(rstN), .instAddr(instAddr), .instData(instData),
  .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .aluResult(aluResult)
);

// File: tb/move_core_test.sv
module move_core_test;

  localparam int PC_W   = 8;
  localparam int DATA_W = 32;
  localparam logic [PC_W-1:0] HALT_PC = 8'd37;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PC_W-1:0]   instAddr;
  logic [31:0]       instData;
  logic              memEn, memWe;
  logic [DATA_W-1:0] memAddr, memWdata, memRdata;
  logic [DATA_W-1:0] netTxData;
  logic              netTxValid;
  logic [DATA_W-1:0] netRxData = 32'hCAFE0001;

  int checks = 0;
  int fails  = 0;

  logic [31:0] prog [0:63];
  logic [31:0] dmem [0:15];

  logic [31:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  move_core uut (
    .clk(clk), .rstN(rstN), .instAddr(instAddr), .instData(instData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .netTxData(netTxData), .netTxValid(netTxValid),
    .netRxData(netRxData)
  );

  assign instData = prog[instAddr[5:0]];
  assign memRdata = dmem[memAddr[3:0]];

  always @(posedge clk) if (memEn && memWe) dmem[memAddr[3:0]] <= memWdata;

  function automatic logic [31:0] enc(input logic [7:0] d, input logic [7:0] s,
                                      input logic [15:0] imm);
    return {d, s, imm};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectTx(input logic [31:0] v, input string req);
    expQ.push_back(v);
    tagQ.push_back(req);
  endtask

  // monitor: scoreboard on the network transmit strobe
  always @(negedge clk) begin
    if (rstN && netTxValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected transmit", netTxData, 32'h0);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(netTxData == e, t, netTxData, e);
      end
    end
  end

  // monitor: memory access windows
  int runLen = 0;
  logic runWe = 1'b0;
  logic [PC_W-1:0] runPc = '0;
  int storeSeen = 0, loadSeen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memEn) begin
        if (runLen == 0) begin
          runWe = memWe;
          runPc = instAddr;
          check(memAddr == 32'd3, "R6 access address", memAddr, 32'd3);
        end else begin
          check(instAddr == runPc, "R6 instAddr frozen during access", 32'(instAddr), 32'(runPc));
        end
        runLen++;
      end else if (runLen != 0) begin
        if (runWe) begin
          storeSeen++;
          check(runLen == 2, "R6 store length", runLen, 2);
        end else begin
          loadSeen++;
          check(runLen == 3, "R6 load length", runLen, 3);
        end
        runLen = 0;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = enc(8'h00, 8'hF0, 16'(i));
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    prog[0]  = enc(8'h30, 8'hF0, 16'd5);
    prog[1]  = enc(8'h31, 8'hF0, 16'd7);
    prog[2]  = enc(8'h40, 8'h37, 16'h0);
    prog[3]  = enc(8'h32, 8'hF0, 16'd20);
    prog[4]  = enc(8'h40, 8'h37, 16'h0);
    prog[5]  = enc(8'h30, 8'hF0, 16'hFF0F);
    prog[6]  = enc(8'h33, 8'hF0, 16'h00FF);
    prog[7]  = enc(8'h40, 8'h37, 16'h0);
    prog[8]  = enc(8'h34, 8'hF0, 16'h0100);
    prog[9]  = enc(8'h40, 8'h37, 16'h0);
    prog[10] = enc(8'h35, 8'hF0, 16'hFFFF);
    prog[11] = enc(8'h40, 8'h37, 16'h0);
    prog[12] = enc(8'h37, 8'hF0, 16'h1234);
    prog[13] = enc(8'h40, 8'h37, 16'h0);
    prog[14] = enc(8'h22, 8'hF0, 16'd99);
    prog[15] = enc(8'h25, 8'h22, 16'h0);
    prog[16] = enc(8'h40, 8'h25, 16'h0);
    prog[17] = enc(8'h10, 8'hF0, 16'd3);
    prog[18] = enc(8'h11, 8'hF0, 16'h4321);
    prog[19] = enc(8'h12, 8'hF0, 16'd3);
    prog[20] = enc(8'h40, 8'h13, 16'h0);
    prog[21] = enc(8'h13, 8'hF0, 16'd7);
    prog[22] = enc(8'h40, 8'h13, 16'h0);
    prog[23] = enc(8'h40, 8'h41, 16'h0);
    prog[24] = enc(8'h30, 8'hF0, 16'd4);
    prog[25] = enc(8'h36, 8'hF0, 16'd5);
    prog[26] = enc(8'h01, 8'hF0, 16'd40);
    prog[27] = enc(8'h40, 8'hF0, 16'd1);
    prog[28] = enc(8'h36, 8'hF0, 16'd4);
    prog[29] = enc(8'h01, 8'hF0, 16'd32);
    prog[30] = enc(8'h40, 8'hF0, 16'h0BAD);
    prog[31] = enc(8'h40, 8'hF0, 16'h0BAD);
    prog[32] = enc(8'h40, 8'h37, 16'h0);
    prog[33] = enc(8'h00, 8'hF0, 16'd36);
    prog[34] = enc(8'h40, 8'hF0, 16'h0BAD);
    prog[35] = enc(8'h40, 8'hF0, 16'h0BAD);
    prog[36] = enc(8'h40, 8'h00, 16'h0);
    prog[37] = enc(8'h00, 8'hF0, 16'(HALT_PC));

    // driver: expected transmit words in program order
    expectTx(32'd12,        "R3 add");
    expectTx(32'hFFFFFFF1,  "R3 sub");
    expectTx(32'h0000000F,  "R1 R3 sign-extended and");
    expectTx(32'hFFFFFF0F,  "R3 or");
    expectTx(32'h000000F0,  "R3 xor");
    expectTx(32'h000000F0,  "R4 alu result write ignored");
    expectTx(32'd99,        "R5 register copy");
    expectTx(32'h00004321,  "R6 store then load");
    expectTx(32'h00004321,  "R4 load data write ignored");
    expectTx(32'hCAFE0001,  "R8 receive read");
    expectTx(32'd1,         "R7 conditional jump not taken");
    expectTx(32'd1,         "R3 R7 compare result after taken jump");
    expectTx(32'd37,        "R7 R2 pc readback after jump");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(instAddr == '0, "R9 reset instAddr", 32'(instAddr), 32'h0);
    check(!memEn && !netTxValid, "R9 reset strobes", {30'h0, memEn, netTxValid}, 32'h0);
    rstN = 1'b1;

    begin
      int cyc = 0;
      int atHalt = 0;
      while (atHalt < 5 && cyc < 5000) begin
        @(negedge clk);
        cyc++;
        if (instAddr == HALT_PC) atHalt++;
        else atHalt = 0;
      end
      check(cyc < 5000, "R1 watchdog", cyc, 5000);
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 all transmits seen", expQ.size(), 0);
    check(storeSeen == 1 && loadSeen == 1, "R6 one store and one load",
          storeSeen * 16 + loadSeen, 17);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule